// File: doc/BRIEF.md
# Burst Descriptor Transfer Engine

This block copies a run of bytes between an external memory port and a local (hub) memory port, one byte per clock. A request is given by a single start pulse that carries a direction, a 24-bit external start address and a 32-bit descriptor. The descriptor packs a hub start address, an item count and a power-of-two item size. The engine works out the byte total from the count and the size. It then reads from the source memory and writes to the destination memory at incrementing addresses on both sides until every byte has been moved.

Both memory ports are synchronous: a read strobe in one cycle returns data in the next cycle. The engine forwards that data in the same cycle, together with the write strobe to the other side. A client can therefore request anything from a single byte, word or long, moved indirectly through the hub address, up to 8 MB with one descriptor. The client waits for the one-cycle done pulse.

Top module: `burst_xfer_engine`

## Requirements
- R1: The descriptor is split as follows: bits 31:24 hold the item count, bits 23:20 hold the size exponent, and bits 19:0 hold the hub start address. Count 1 with exponent 0, 1 or 2 moves exactly 1, 2 or 4 bytes.
- R2: An item count of 0 means 256 items.
- R3: The byte total is the effective item count multiplied by 2 raised to the exponent. Exactly that many source reads and that many destination writes occur.
- R4: With `dir_write_i` = 1 (hub to external), read i goes to the hub at hub base + i in cycle S+1+i, where S is the start cycle. Write i goes to external address base + i in the following cycle, and carries the byte that the hub returned for read i. No external read and no hub write occur.
- R5: With `dir_write_i` = 0 (external to hub), read i goes to the external side at external base + i. Write i goes to hub base + i one cycle later and carries the byte that the external side returned. No hub read and no external write occur.
- R6: Hub addresses wrap modulo 2^20 and external addresses wrap modulo 2^24.
- R7: For a request of N bytes started in cycle S, `busy_o` is high from cycle S+1 through S+N+1. `done_o` is high only in cycle S+N+2, and `busy_o` is low in that cycle.
- R8: A start pulse while `busy_o` is high is ignored. The direction, the addresses and the descriptor are captured only in the accepting start cycle, so later changes on those inputs have no effect.
- R9: After reset the engine is idle, with `busy_o`, `done_o` and all four strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request pulse, accepted while idle |
| dir_write_i | input | 1 | 1: hub to external, 0: external to hub |
| ext_addr_i | input | 24 | External start address |
| desc_i | input | 32 | Count, size exponent and hub start address |
| ext_rd_o | output | 1 | External read strobe |
| ext_wr_o | output | 1 | External write strobe |
| ext_addr_o | output | 24 | External address |
| ext_wdata_o | output | 8 | External write data |
| ext_rdata_i | input | 8 | External read data, one cycle after the read |
| hub_rd_o | output | 1 | Hub read strobe |
| hub_wr_o | output | 1 | Hub write strobe |
| hub_addr_o | output | 20 | Hub address |
| hub_wdata_o | output | 8 | Hub write data |
| hub_rdata_i | input | 8 | Hub read data, one cycle after the read |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
After the start edge, the bench counts observation windows. In window j, read j-1 is due for j up to N, write j-2 is due for j from 2 to N+1, and done is due only in window N+2. The bench samples every window on the falling clock edge, so each register on the path has already settled. Expected addresses and data come from bench functions applied to the captured bases. The memory models return an address-derived pattern one cycle after each read. Start pulses and new input values injected in mid-transfer windows must leave the window-by-window sequence unchanged.

// File: rtl/burst_xfer_pkg.sv
package burst_xfer_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MOVE  = 2'd1,
    ST_FLUSH = 2'd2
  } xfer_state_e;
endpackage

// File: rtl/burst_len_calc.sv
module burst_len_calc #(
  parameter int CNT_W = 8,
  parameter int EXP_W = 4,
  parameter int LEN_W = 24
) (
  input  logic [CNT_W-1:0] count_i,
  input  logic [EXP_W-1:0] exp_i,
  output logic [LEN_W-1:0] len_o
);
  logic [CNT_W:0] items;

  always_comb begin
    // zero count stands for the full 2^CNT_W items
    items = (count_i == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, count_i};
    len_o = LEN_W'(items) << exp_i;
  end
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr #(
  parameter int AW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] base_i,
  input  logic          step_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] addr_q, addr_d;
  logic          addr_en;

  always_comb begin
    addr_en = load_i | step_i;
    addr_d  = load_i ? base_i : addr_q + AW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/burst_ctrl.sv
module burst_ctrl
  import burst_xfer_pkg::*;
#(
  parameter int LEN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             load_o,
  output logic             rd_o,
  output logic             wr_o,
  output logic             busy_o,
  output logic             done_o
);
  xfer_state_e      state_q, state_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             wr_q, wr_d;
  logic             done_q, done_d;

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    wr_d    = 1'b0;
    done_d  = 1'b0;
    load_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_o  = 1'b1;
          rem_d   = len_i;
          state_d = ST_MOVE;
        end
      end
      ST_MOVE: begin
        wr_d  = 1'b1;
        rem_d = rem_q - LEN_W'(1);
        if (rem_q == LEN_W'(1)) state_d = ST_FLUSH;
      end
      ST_FLUSH: begin
        done_d  = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      rem_q   <= '0;
      wr_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      wr_q    <= wr_d;
      done_q  <= done_d;
    end
  end

  assign rd_o   = (state_q == ST_MOVE);
  assign wr_o   = wr_q;
  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;
endmodule

// File: rtl/burst_xfer_engine.sv
module burst_xfer_engine #(
  parameter int EXT_AW = 24,
  parameter int HUB_AW = 20,
  parameter int DATA_W = 8,
  parameter int CNT_W  = 8,
  parameter int EXP_W  = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            start_i,
  input  logic                            dir_write_i,
  input  logic [EXT_AW-1:0]               ext_addr_i,
  input  logic [CNT_W+EXP_W+HUB_AW-1:0]   desc_i,
  output logic                            ext_rd_o,
  output logic                            ext_wr_o,
  output logic [EXT_AW-1:0]               ext_addr_o,
  output logic [DATA_W-1:0]               ext_wdata_o,
  input  logic [DATA_W-1:0]               ext_rdata_i,
  output logic                            hub_rd_o,
  output logic                            hub_wr_o,
  output logic [HUB_AW-1:0]               hub_addr_o,
  output logic [DATA_W-1:0]               hub_wdata_o,
  input  logic [DATA_W-1:0]               hub_rdata_i,
  output logic                            busy_o,
  output logic                            done_o
);
  localparam int DESC_W = CNT_W + EXP_W + HUB_AW;
  localparam int LEN_W  = CNT_W + (2 ** EXP_W);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  logic [CNT_W-1:0]  f_count;
  logic [EXP_W-1:0]  f_exp;
  logic [HUB_AW-1:0] f_hub;
  logic [LEN_W-1:0]  req_len;
  logic              load, rd_act, wr_act;
  logic              dir_q;
  logic              ext_step, hub_step;

  assign f_count = desc_i[DESC_W-1 -: CNT_W];
  assign f_exp   = desc_i[HUB_AW +: EXP_W];
  assign f_hub   = desc_i[HUB_AW-1:0];

  burst_len_calc #(.CNT_W(CNT_W), .EXP_W(EXP_W), .LEN_W(LEN_W)) u_len (
    .count_i (f_count),
    .exp_i   (f_exp),
    .len_o   (req_len)
  );

  burst_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .start_i (start_i),
    .len_i   (req_len),
    .load_o  (load),
    .rd_o    (rd_act),
    .wr_o    (wr_act),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) dir_q <= 1'b0;
    else if (load)   dir_q <= dir_write_i;
  end

  // source side advances on reads, destination side on writes
  assign ext_step = dir_q ? wr_act : rd_act;
  assign hub_step = dir_q ? rd_act : wr_act;

  burst_addr_ctr #(.AW(EXT_AW)) u_ext_ctr (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .load_i (load),
    .base_i (ext_addr_i),
    .step_i (ext_step),
    .addr_o (ext_addr_o)
  );

  burst_addr_ctr #(.AW(HUB_AW)) u_hub_ctr (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .load_i (load),
    .base_i (f_hub),
    .step_i (hub_step),
    .addr_o (hub_addr_o)
  );

  assign ext_rd_o    = rd_act & ~dir_q;
  assign hub_rd_o    = rd_act &  dir_q;
  assign ext_wr_o    = wr_act &  dir_q;
  assign hub_wr_o    = wr_act & ~dir_q;
  assign ext_wdata_o = hub_rdata_i;
  assign hub_wdata_o = ext_rdata_i;
endmodule

// File: rtl/burst_xfer_engine_chk.sv
module burst_xfer_engine_chk #(
  parameter int EXT_AW = 24,
  parameter int HUB_AW = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_i,
  input logic              ext_rd_o,
  input logic              ext_wr_o,
  input logic [EXT_AW-1:0] ext_addr_o,
  input logic              hub_rd_o,
  input logic              hub_wr_o,
  input logic [HUB_AW-1:0] hub_addr_o,
  input logic              busy_o,
  input logic              done_o
);
  // R7
  done_alone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));

  // R7
  start_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_o && !done_o && !$past(start_i)) |=> busy_o);

  // R4
  ext_wr_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ext_wr_o |-> $past(hub_rd_o) || $past(hub_wr_o) == 1'b0 && $past(busy_o));

  // R5
  hub_wr_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hub_wr_o |-> !hub_rd_o && !ext_wr_o);

  // R4
  one_side_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ext_rd_o, hub_rd_o}) && $onehot0({ext_wr_o, hub_wr_o}));

  // R6
  hub_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hub_rd_o && $past(hub_rd_o)) |-> hub_addr_o == HUB_AW'($past(hub_addr_o) + 1'b1));

  // R6
  ext_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd_o && $past(ext_rd_o)) |-> ext_addr_o == EXT_AW'($past(ext_addr_o) + 1'b1));
endmodule

bind burst_xfer_engine burst_xfer_engine_chk #(.EXT_AW(EXT_AW), .HUB_AW(HUB_AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .ext_rd_o   (ext_rd_o),
  .ext_wr_o   (ext_wr_o),
  .ext_addr_o (ext_addr_o),
  .hub_rd_o   (hub_rd_o),
  .hub_wr_o   (hub_wr_o),
  .hub_addr_o (hub_addr_o),
  .busy_o     (busy_o),
  .done_o     (done_o)
);

// File: tb/burst_xfer_engine_test.sv
module burst_xfer_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 190000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic        dir_write_i;
  logic [23:0] ext_addr_i;
  logic [31:0] desc_i;
  logic        ext_rd_o, ext_wr_o, hub_rd_o, hub_wr_o, busy_o, done_o;
  logic [23:0] ext_addr_o;
  logic [19:0] hub_addr_o;
  logic [7:0]  ext_wdata_o, hub_wdata_o;
  logic [7:0]  ext_rdata_i, hub_rdata_i;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_xfer_engine uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .dir_write_i(dir_write_i),
    .ext_addr_i(ext_addr_i), .desc_i(desc_i),
    .ext_rd_o(ext_rd_o), .ext_wr_o(ext_wr_o), .ext_addr_o(ext_addr_o),
    .ext_wdata_o(ext_wdata_o), .ext_rdata_i(ext_rdata_i),
    .hub_rd_o(hub_rd_o), .hub_wr_o(hub_wr_o), .hub_addr_o(hub_addr_o),
    .hub_wdata_o(hub_wdata_o), .hub_rdata_i(hub_rdata_i),
    .busy_o(busy_o), .done_o(done_o)
  );

  function automatic logic [7:0] pat_ext(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'hA5;
  endfunction

  function automatic logic [7:0] pat_hub(input logic [19:0] a);
    return a[7:0] ^ {4'h3, a[19:16]} ^ a[15:8] ^ 8'h3C;
  endfunction

  function automatic int byte_total(input logic [31:0] d);
    int items;
    items = (d[31:24] == 8'd0) ? 256 : int'(d[31:24]);
    return items << d[23:20];
  endfunction

  // synchronous memory models: data one cycle after the read strobe
  always @(posedge clk) begin
    if (ext_rd_o) ext_rdata_i <= pat_ext(ext_addr_o);
    if (hub_rd_o) hub_rdata_i <= pat_hub(hub_addr_o);
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_xfer(input bit dir, input logic [23:0] ebase, input logic [31:0] desc,
                          input int glitch_win, input string tag);
    int n;
    logic [19:0] hbase;
    logic [3:0]  exp_strb, act_strb;
    n     = byte_total(desc);
    hbase = desc[19:0];
    @(negedge clk);
    start_i     = 1'b1;
    dir_write_i = dir;
    ext_addr_i  = ebase;
    desc_i      = desc;
    @(negedge clk);
    start_i = 1'b0;
    // R8: inputs changed after capture must not matter
    dir_write_i = ~dir;
    ext_addr_i  = 24'($urandom);
    desc_i      = $urandom;
    for (int j = 1; j <= n + 2; j++) begin
      bit rd_due, wr_due;
      rd_due   = (j <= n);
      wr_due   = (j >= 2) && (j <= n + 1);
      exp_strb = dir ? {1'b0, wr_due, rd_due, 1'b0} : {rd_due, 1'b0, 1'b0, wr_due};
      act_strb = {ext_rd_o, ext_wr_o, hub_rd_o, hub_wr_o};
      chk(act_strb == exp_strb, "R3", "strobes {erd,ewr,hrd,hwr}", 32'(act_strb), 32'(exp_strb));
      chk(busy_o == (j <= n + 1) && done_o == (j == n + 2), "R7", "{busy,done}",
          {30'd0, busy_o, done_o}, {30'd0, 1'(j <= n + 1), 1'(j == n + 2)});
      if (dir) begin
        if (rd_due) chk(hub_addr_o == 20'(hbase + 20'(j - 1)), tag, "R4 hub read addr",
                        32'(hub_addr_o), 32'(20'(hbase + 20'(j - 1))));
        if (wr_due) begin
          chk(ext_addr_o == 24'(ebase + 24'(j - 2)), tag, "R4 ext write addr",
              32'(ext_addr_o), 32'(24'(ebase + 24'(j - 2))));
          chk(ext_wdata_o == pat_hub(20'(hbase + 20'(j - 2))), "R4", "ext write data",
              32'(ext_wdata_o), 32'(pat_hub(20'(hbase + 20'(j - 2)))));
        end
      end else begin
        if (rd_due) chk(ext_addr_o == 24'(ebase + 24'(j - 1)), tag, "R5 ext read addr",
                        32'(ext_addr_o), 32'(24'(ebase + 24'(j - 1))));
        if (wr_due) begin
          chk(hub_addr_o == 20'(hbase + 20'(j - 2)), tag, "R5 hub write addr",
              32'(hub_addr_o), 32'(20'(hbase + 20'(j - 2))));
          chk(hub_wdata_o == pat_ext(24'(ebase + 24'(j - 2))), "R5", "hub write data",
              32'(hub_wdata_o), 32'(pat_ext(24'(ebase + 24'(j - 2)))));
        end
      end
      // R8: start pulse while busy
      start_i = (j == glitch_win) && (j <= n + 1);
      if (j < n + 2) @(negedge clk);
    end
    start_i = 1'b0;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start_i = 1'b0; dir_write_i = 1'b0;
    ext_addr_i = '0; desc_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9
    chk({busy_o, done_o, ext_rd_o, ext_wr_o, hub_rd_o, hub_wr_o} == 6'd0, "R9",
        "idle outputs after reset", {26'd0, busy_o, done_o, ext_rd_o, ext_wr_o, hub_rd_o, hub_wr_o}, 32'd0);

    // R1: single byte, word and long moved indirectly
    run_xfer(1'b0, 24'h001000, {8'd1, 4'd0, 20'h00040}, 0, "R1");
    run_xfer(1'b1, 24'h002000, {8'd1, 4'd1, 20'h00080}, 0, "R1");
    run_xfer(1'b1, 24'h003000, {8'd1, 4'd2, 20'h000C0}, 0, "R1");
    // R2: zero count is 256 items
    run_xfer(1'b0, 24'h123456, {8'd0, 4'd0, 20'h01000}, 0, "R2");
    // R6: hub wrap in both directions, external wrap
    run_xfer(1'b0, 24'h000010, {8'd6, 4'd0, 20'hFFFFD}, 0, "R6");
    run_xfer(1'b1, 24'h000020, {8'd3, 4'd1, 20'hFFFFE}, 0, "R6");
    run_xfer(1'b1, 24'hFFFFFC, {8'd8, 4'd0, 20'h00200}, 0, "R6");
    run_xfer(1'b0, 24'hFFFFFE, {8'd2, 4'd1, 20'h00300}, 0, "R6");
    // R8: start during transfer, early and on the flush cycle
    run_xfer(1'b1, 24'h040000, {8'd10, 4'd1, 20'h05000}, 3, "R8");
    run_xfer(1'b0, 24'h050000, {8'd4, 4'd0, 20'h06000}, 5, "R8");
    // R3: long request from a zero count and a large exponent
    run_xfer(1'b0, 24'h700000, {8'd0, 4'd6, 20'h10000}, 100, "R3");

    for (int k = 0; k < 30; k++) begin
      logic [31:0] d;
      d = {8'($urandom), 4'($urandom % 4), 20'($urandom)};
      run_xfer(1'($urandom), 24'($urandom), d, int'($urandom % 8), "R3");
    end

    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule